// File: doc/BRIEF.md
# SDRAM Power and Command Control Unit

This unit turns a small software-written control register into SDRAM power-state and command activity. Software steps the memory through its power-up sequence by writing a two-bit command selector: each write produces one single-cycle command strobe. Software also uses the register to request self-refresh and deep power-down, and to choose how the SDRAM clock and the per-device clock-enable (CKE) lines behave when the memory is idle.

Self-refresh uses a request/acknowledge handshake. Entry waits until no transaction is pending. Exit raises CKE and issues a no-op before the acknowledge bit drops, so software polls that bit to learn the real mode. The clock gate and the CKE lines follow the per-device idle flags, the transaction-pending flag, the power state and the register settings. Only one command strobe is ever active in a cycle. A command-selector write that arrives while the unit is not in its running state is held and is issued on return.

Top module: `sdram_pwr_ctl`

Register layout (`reg_wdata` / `reg_rdata`):
- bit 0: `ce_hold`
- bit 1: `clk_run`
- bit 2: `sr_req`
- bit 3: `clk_off`
- bits 5:4: `init`
- bit 6: `dpd`
- bit 7: reserved

## Requirements
- R1: After reset, `reg_rdata` reads 0x06 (`clk_run`=1, `sr_req`=1, everything else 0), `sref_ack` is 0 and no command strobe is active.
- R2: A write (`reg_wr`=1) stores `reg_wdata[6:0]` at the clock edge. `reg_rdata[7]` always reads 0.
- R3: A register write causes, one cycle after the write edge (provided the unit is running), exactly one single-cycle strobe chosen by `init`: 00 `cmd_norm`, 01 `cmd_mrs`, 10 `cmd_pall`, 11 `cmd_nop`. Writing the same value again issues the strobe again.
- R4: At most one of the six command strobes is high in any cycle.
- R4: A write made outside the running state is held until the unit returns to running. In the running state, a held command is issued before any self-refresh or power-down entry.
- R5: Self-refresh entry happens only in a running cycle with `sr_req`=1, no held command and `xfer_pend`=0. In that cycle `cmd_sref` pulses, `sref_ack` rises and every CKE line is low.
- R6: Clearing `sr_req` during self-refresh gives the following sequence:
  - one cycle with `cmd_nop` high, all CKE lines high and `sref_ack` still 1;
  - then `sref_ack` returns to 0.
- R7: With `sr_req`=0, `dpd`=1 and `xfer_pend`=0, a running unit pulses `cmd_dpd` and holds all CKE lines low until `dpd` is cleared. Running resumes in the cycle after `dpd` is cleared.
- R8: Outside self-refresh and deep power-down, CKE line i is high if any of the following holds:
  - `ce_hold`=1;
  - `init`≠00;
  - `dev_idle[i]`=0.
  Otherwise it is low.
- R9: With `clk_run`=0, `sdclk_en` is 0 when all devices are idle and no transaction is pending, and also during self-refresh or deep power-down. With `clk_run`=1 and `clk_off`=0 it is 1.
- R10: With `clk_off`=1, `sdclk_en` is 0 whenever `xfer_pend`=0. A pending transaction keeps the clock running.
- R11: `sdclk_en` is 1 in every cycle in which a command strobe is active, whatever the gating settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| dev_idle | input | NDEV | Per-device idle flags |
| xfer_pend | input | 1 | An SDRAM transaction is outstanding |
| cmd_norm | output | 1 | Normal-operation command strobe |
| cmd_mrs | output | 1 | Mode-register command strobe |
| cmd_pall | output | 1 | Precharge-all command strobe |
| cmd_nop | output | 1 | No-op command strobe |
| cmd_sref | output | 1 | Self-refresh entry command strobe |
| cmd_dpd | output | 1 | Deep power-down entry command strobe |
| sdclk_en | output | 1 | SDRAM clock gate enable |
| cke | output | NDEV | Per-device clock enable |
| sref_ack | output | 1 | Self-refresh acknowledge status |

## Verification
Two functions can collide in the same cycle. One is the command a register write requests. The other is a strobe the power sequencer wants to emit, either the exit no-op or the entry of self-refresh or power-down. The bench provokes the collision in two ways:
- It writes a command selector in the same cycle that clears `sr_req`, and again while the exit sequence runs.
- It writes back-to-back while a held command is being issued. Random traffic then repeats these cases many times.

A cycle-accurate reference model in the bench predicts which single strobe wins each cycle and the cycle in which the deferred command appears. The design must match the model on every clock.

// File: rtl/sdram_pwr_ctl.sv
module sdram_pwr_ctl #(
  parameter int NDEV = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic [NDEV-1:0] dev_idle,
  input  logic            xfer_pend,
  output logic            cmd_norm,
  output logic            cmd_mrs,
  output logic            cmd_pall,
  output logic            cmd_nop,
  output logic            cmd_sref,
  output logic            cmd_dpd,
  output logic            sdclk_en,
  output logic [NDEV-1:0] cke,
  output logic            sref_ack
);
  localparam logic [6:0] CTL_RST = 7'h06;

  typedef enum logic [1:0] {S_RUN, S_SREF, S_EXIT, S_DPD} st_t;

  st_t        st;
  logic [6:0] ctl;
  logic       init_pend;
  logic [5:0] cmd;

  logic       ce_hold, clk_run, sr_req, clk_off, dpd;
  logic [1:0] init;

  assign ce_hold = ctl[0];
  assign clk_run = ctl[1];
  assign sr_req  = ctl[2];
  assign clk_off = ctl[3];
  assign init    = ctl[5:4];
  assign dpd     = ctl[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_RUN;
      ctl       <= CTL_RST;
      init_pend <= 1'b0;
      cmd       <= '0;
    end else begin
      cmd <= '0;
      case (st)
        S_RUN:
          if (init_pend) cmd[{1'b0, init}] <= 1'b1;
          else if (sr_req && !xfer_pend) begin
            st     <= S_SREF;
            cmd[4] <= 1'b1;
          end else if (dpd && !xfer_pend) begin
            st     <= S_DPD;
            cmd[5] <= 1'b1;
          end
        S_SREF:
          if (!sr_req) begin
            st     <= S_EXIT;
            cmd[3] <= 1'b1;
          end
        S_EXIT:  st <= S_RUN;
        default: if (!dpd) st <= S_RUN;
      endcase
      init_pend <= reg_wr | (init_pend & (st != S_RUN));
      if (reg_wr) ctl <= reg_wdata[6:0];
    end
  end

  assign {cmd_dpd, cmd_sref, cmd_nop, cmd_pall, cmd_mrs, cmd_norm} = cmd;

  logic lowpwr, gate_off;
  assign lowpwr   = (st == S_SREF) || (st == S_DPD);
  assign gate_off = (clk_off & ~xfer_pend)
                  | (~clk_run & ((&dev_idle & ~xfer_pend) | lowpwr));
  assign sdclk_en = (|cmd) | ~gate_off;

  for (genvar i = 0; i < NDEV; i++) begin : g_cke
    assign cke[i] = (st == S_EXIT)
                  | (~lowpwr & (ce_hold | (init != 2'b00) | ~dev_idle[i]));
  end

  assign sref_ack  = (st == S_SREF) || (st == S_EXIT);
  assign reg_rdata = {1'b0, ctl};
endmodule

module sdram_pwr_ctl_chk #(
  parameter int NDEV = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xfer_pend,
  input logic            cmd_norm,
  input logic            cmd_mrs,
  input logic            cmd_pall,
  input logic            cmd_nop,
  input logic            cmd_sref,
  input logic            cmd_dpd,
  input logic            sdclk_en,
  input logic [NDEV-1:0] cke,
  input logic            sref_ack
);
  logic [5:0] strobes;
  assign strobes = {cmd_dpd, cmd_sref, cmd_nop, cmd_pall, cmd_mrs, cmd_norm};

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

  a_r5_sref_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sref |-> (cke == '0) && sref_ack);

  a_r5_entry_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sref_ack) |-> $past(!xfer_pend));

  a_r6_ack_after_nop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sref_ack) |-> $past(cmd_nop) && $past(cke == '1));

  a_r7_dpd_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dpd |-> (cke == '0) && !sref_ack);

  a_r11_clock_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobes) |-> sdclk_en);
endmodule

bind sdram_pwr_ctl sdram_pwr_ctl_chk #(.NDEV(NDEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_pend(xfer_pend),
  .cmd_norm(cmd_norm), .cmd_mrs(cmd_mrs), .cmd_pall(cmd_pall),
  .cmd_nop(cmd_nop), .cmd_sref(cmd_sref), .cmd_dpd(cmd_dpd),
  .sdclk_en(sdclk_en), .cke(cke), .sref_ack(sref_ack)
);

// File: tb/tb_sdram_pwr_ctl.sv
module tb_sdram_pwr_ctl;
  localparam int NDEV = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr = 1'b0;
  logic [7:0]      reg_wdata = '0;
  logic [7:0]      reg_rdata;
  logic [NDEV-1:0] dev_idle = '1;
  logic            xfer_pend = 1'b0;
  logic            cmd_norm, cmd_mrs, cmd_pall, cmd_nop, cmd_sref, cmd_dpd;
  logic            sdclk_en, sref_ack;
  logic [NDEV-1:0] cke;

  always #2.5 clk = ~clk;

  sdram_pwr_ctl #(.NDEV(NDEV)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dev_idle(dev_idle), .xfer_pend(xfer_pend),
    .cmd_norm(cmd_norm), .cmd_mrs(cmd_mrs), .cmd_pall(cmd_pall),
    .cmd_nop(cmd_nop), .cmd_sref(cmd_sref), .cmd_dpd(cmd_dpd),
    .sdclk_en(sdclk_en), .cke(cke), .sref_ack(sref_ack)
  );

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  // Reference model. Mode: 0 running, 1 self-refresh, 2 exit, 3 deep power-down.
  // Strobe vector order: {dpd, sref, nop, pall, mrs, norm}
  logic [6:0] m_ctl;
  bit         m_pend;
  int         m_mode;
  logic [5:0] m_cmd;
  int         n_mode;
  logic [5:0] n_cmd;
  bit         n_used;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 7'h06; m_pend = 0; m_mode = 0; m_cmd = '0;
    end else begin
      n_mode = m_mode; n_cmd = '0; n_used = 0;
      case (m_mode)
        0: begin
          if (m_pend) begin
            n_cmd[m_ctl[5:4]] = 1'b1; n_used = 1;
          end else if (m_ctl[2] && !xfer_pend) begin
            n_mode = 1; n_cmd[4] = 1'b1;
          end else if (m_ctl[6] && !xfer_pend) begin
            n_mode = 3; n_cmd[5] = 1'b1;
          end
        end
        1: if (!m_ctl[2]) begin n_mode = 2; n_cmd[3] = 1'b1; end
        2: n_mode = 0;
        default: if (!m_ctl[6]) n_mode = 0;
      endcase
      m_pend = reg_wr || (m_pend && !n_used);
      if (reg_wr) m_ctl = reg_wdata[6:0];
      m_mode = n_mode;
      m_cmd  = n_cmd;
    end
  end

  task automatic fail(string req, string what, int act, int exp);
    nfail++;
    $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
  endtask

  task automatic compare();
    logic [NDEV-1:0] e_cke;
    bit e_clk, stop, lowpwr;
    logic [5:0] got;
    lowpwr = (m_mode == 1) || (m_mode == 3);
    for (int i = 0; i < NDEV; i++)
      e_cke[i] = (m_mode == 2) ||
                 (!lowpwr && (m_ctl[0] || m_ctl[5:4] != 2'b00 || !dev_idle[i]));
    stop = (m_ctl[3] && !xfer_pend) ||
           (!m_ctl[1] && ((dev_idle == '1 && !xfer_pend) || lowpwr));
    e_clk = (m_cmd != 0) || !stop;
    got = {cmd_dpd, cmd_sref, cmd_nop, cmd_pall, cmd_mrs, cmd_norm};
    nvec++;
    if (reg_rdata !== {1'b0, m_ctl}) fail("R1/R2", "reg_rdata", reg_rdata, {1'b0, m_ctl});
    if (got !== m_cmd) fail("R3/R4/R5/R6/R7", "strobes", got, m_cmd);
    if (sref_ack !== (m_mode == 1 || m_mode == 2)) fail("R5/R6", "sref_ack", sref_ack, (m_mode == 1 || m_mode == 2));
    if (cke !== e_cke) fail("R5/R7/R8", "cke", cke, e_cke);
    if (sdclk_en !== e_clk) fail("R9/R10/R11", "sdclk_en", sdclk_en, e_clk);
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic step(bit w, logic [7:0] d, logic [NDEV-1:0] idl, bit p);
    reg_wr = w; reg_wdata = d; dev_idle = idl; xfer_pend = p;
    tick();
  endtask

  task automatic idle_n(int n, logic [NDEV-1:0] idl, bit p);
    for (int i = 0; i < n; i++) step(0, 8'h00, idl, p);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) tick();          // R1 reset values
    rst_n = 1'b1;
    idle_n(4, 4'b1111, 1);                       // R5 entry waits for pending
    idle_n(4, 4'b1111, 0);                       // R5 entry, cke low
    step(1, 8'h01, 4'b1111, 0);                  // R6 clear sr_req, ce_hold
    step(1, 8'h31, 4'b1111, 0);                  // R4 nop collision during exit
    idle_n(4, 4'b0101, 0);
    step(1, 8'h10, 4'b0011, 0);                  // R3 mode command
    step(1, 8'h20, 4'b0011, 0);                  // R3 precharge all
    step(1, 8'h20, 4'b0011, 0);                  // R3 rewrite reissues
    step(1, 8'h30, 4'b0011, 0);
    step(1, 8'h00, 4'b0011, 0);                  // R3 normal
    idle_n(3, 4'b0110, 0);                       // R8 idle-gated cke
    step(1, 8'h01, 4'b0110, 0);                  // R8 ce_hold
    idle_n(2, 4'b1111, 0);
    step(1, 8'h80, 4'b1111, 0);                  // R2 reserved bit reads 0
    idle_n(3, 4'b1111, 0);                       // R9 clock stops when idle
    idle_n(2, 4'b1110, 0);
    idle_n(2, 4'b1111, 1);
    step(1, 8'h0a, 4'b1111, 1);                  // R10 clk_off with pending
    idle_n(3, 4'b1111, 0);                       // R10 clk_off no pending
    step(1, 8'h42, 4'b1111, 1);                  // R7 dpd waits for pending
    idle_n(2, 4'b1111, 1);
    idle_n(4, 4'b1111, 0);
    step(1, 8'h60, 4'b1111, 0);                  // R4 write held in dpd
    step(1, 8'h20, 4'b1111, 0);
    idle_n(4, 4'b0000, 0);
    step(1, 8'h04, 4'b1111, 0);                  // R11 sref with clock stop
    idle_n(3, 4'b1111, 0);
    step(1, 8'h24, 4'b1111, 0);                  // R4 held pall during sref
    step(1, 8'h10, 4'b1111, 0);                  // R6 exit plus held mrs
    idle_n(4, 4'b1111, 0);
    for (int i = 0; i < 4000; i++) begin
      bit w;
      w = ($urandom % 5) == 0;
      step(w, 8'($urandom), 4'($urandom), ($urandom % 3) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule